// File: doc/BRIEF.md
# Transmit Gain Index Compensator

This block converts a requested transmit power into the index of a gain table, in which each step is half a decibel and a larger index gives less gain. When a start strobe arrives it samples everything at once: the request, the regulatory and saturation ceilings, the rate class, band and channel, the factory calibration point (index, power, temperature), the present temperature, the factory and present supply codes, the hardware revision and a table of per-group, per-chain MIMO attenuation values.

A small sequential datapath then works through the corrections. It caps the target power, moves the factory index by the power difference, and applies the temperature and supply-voltage corrections. For MIMO rates it adds the chain balance value, and for CCK rates a revision-dependent step. Finally it clamps the index to the table selected by the band. The two divisions, by a fractional temperature slope and by the supply-code ratio, share one serial restoring divider that works on doubled magnitudes and truncates toward zero. The result is presented with a one-cycle done pulse and held until the next result.

Top module: `tx_gain_comp`

## Requirements
- R1: The effective target in half-dB units is the smallest of `target_hdb`, `reg_hdb` less 6 when `mimo` is 1, and `sat_hdb` less a backoff chosen by `rate_code`. The backoffs are: 0 (CCK) 10, 1 (OFDM 6–36 Mbit/s) 10, 2 (48 Mbit/s) 15, 3 (54 Mbit/s) 17, 4 (60 Mbit/s) 20, and 5–7 10. The target is then clamped to 0..32.
- R2: The base index is `fact_idx + fact_hdb − target`.
- R3: With dT = `cur_temp − fact_temp` and m = |dT|, the temperature step count is trunc(2m/7) for 2.4 GHz (`band_hi`=0), trunc(2m/9) for 5 GHz channels below 44, and trunc(2m/8) for 5 GHz channels 44 and above. The count is subtracted from the index when dT>0 and added when dT<0.
- R4: When `cur_vcode < fact_vcode` the index grows by trunc((fact−cur)/7). When `cur_vcode > fact_vcode` it shrinks by trunc(2·(cur−fact)/7).
- R5: A voltage step count larger than 2 is replaced by 0.
- R6: When `mimo` is 1, the index grows by the 4-bit unsigned value at `atten_tab[(g*2+chain_sel)*4 +: 4]`. The group g is 4 for 2.4 GHz. For 5 GHz it is 0 for channels ≤43, 1 for 44–70, 2 for 71–124 and 3 for the rest.
- R7: When `rate_code` is 0 (CCK), the index grows by 9 if `hw_rev` (bits [3:2] of the revision word) is 1, by 5 if it is 2, and by 0 otherwise.
- R8: The final index is clamped to 0..98 when `band_hi`=0 and to −9..98 when `band_hi`=1. It is output as a two's-complement 8-bit value.
- R9: `done` is a single-cycle pulse 24 clock edges after the edge that samples `start`. `gain_idx` changes only with `done` and holds between results. A `start` during a computation is ignored.
- R10: After reset `done` is 0 and `gain_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample all operands and begin |
| target_hdb | input | 8 | Requested power, signed, half-dBm |
| reg_hdb | input | 8 | Regulatory ceiling, unsigned, half-dBm |
| sat_hdb | input | 8 | Saturation ceiling, unsigned, half-dBm |
| rate_code | input | 3 | Rate class code (R1) |
| mimo | input | 1 | Two-transmitter rate |
| band_hi | input | 1 | 1 = 5 GHz, 0 = 2.4 GHz |
| chan | input | 8 | Channel number |
| fact_idx | input | 8 | Factory gain index, signed |
| fact_hdb | input | 8 | Factory measured power, signed, half-dBm |
| fact_temp | input | 8 | Factory temperature, signed, °C |
| cur_temp | input | 8 | Present temperature, signed, °C |
| fact_vcode | input | 8 | Factory supply code |
| cur_vcode | input | 8 | Present supply code |
| hw_rev | input | 2 | Revision field |
| chain_sel | input | 1 | Transmit chain |
| atten_tab | input | 40 | Ten 4-bit balance values (R6) |
| done | output | 1 | Result strobe |
| gain_idx | output | 8 | Final index, signed |

## Verification
The bench targets the points where the corrections are easiest to get wrong. At the exact 2/7 boundaries a divider that rounds would take a step early. A negative temperature difference shows whether truncation goes toward zero or toward minus infinity. A supply-code gap that yields three steps must give zero rather than three. The channel-43/44 and 124/125 edges catch a group or slope that is off by one channel. Clamping is checked at both ends of both tables, where a design using one floor for both bands gives 0 instead of −9. A second start fired mid-computation checks that the operands of the running computation are not overwritten.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    localparam int DATA_W   = 8;
    localparam int TGT_W    = 6;
    localparam int BASE_W   = 11;
    localparam int ACC_W    = 12;
    localparam int DVS_W    = 4;
    localparam int DIV_W    = DATA_W + 2;

    localparam int TGT_MAX    = 32;
    localparam int MIMO_CUT   = 6;
    localparam int IDX_TOP    = 98;
    localparam int IDX_BOT_LO = 0;
    localparam int IDX_BOT_HI = -9;
    localparam int VOLT_DVS   = 7;
    localparam int VOLT_CAP   = 2;
    localparam int CCK_REV_B  = 9;
    localparam int CCK_REV_C  = 5;

    typedef enum logic [2:0] {
        RC_CCK      = 3'd0,
        RC_OFDM_LOW = 3'd1,
        RC_OFDM_48  = 3'd2,
        RC_OFDM_54  = 3'd3,
        RC_OFDM_60  = 3'd4
    } rate_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PREP, ST_TDIV, ST_VDIV, ST_FIN
    } state_e;

    typedef struct packed {
        logic signed [DATA_W-1:0] target;
        logic        [DATA_W-1:0] reg_lim;
        logic        [DATA_W-1:0] sat_lim;
        logic        [2:0]        rate;
        logic                     mimo;
        logic                     band_hi;
        logic        [DATA_W-1:0] chan;
        logic signed [DATA_W-1:0] f_idx;
        logic signed [DATA_W-1:0] f_pwr;
        logic signed [DATA_W-1:0] f_temp;
        logic signed [DATA_W-1:0] c_temp;
        logic        [DATA_W-1:0] f_volt;
        logic        [DATA_W-1:0] c_volt;
        logic        [1:0]        rev;
    } op_t;

    function automatic logic [4:0] backoff_steps(input logic [2:0] rc);
        case (rc)
            RC_OFDM_48: return 5'd15;
            RC_OFDM_54: return 5'd17;
            RC_OFDM_60: return 5'd20;
            default:    return 5'd10;
        endcase
    endfunction

    function automatic logic [2:0] atten_group(input logic hi, input logic [DATA_W-1:0] ch);
        if (!hi)            return 3'd4;
        else if (ch <= 43)  return 3'd0;
        else if (ch <= 70)  return 3'd1;
        else if (ch <= 124) return 3'd2;
        else                return 3'd3;
    endfunction

    function automatic logic [DVS_W-1:0] temp_divisor(input logic hi, input logic [DATA_W-1:0] ch);
        if (!hi)          return DVS_W'(7);
        else if (ch < 44) return DVS_W'(9);
        else              return DVS_W'(8);
    endfunction

    function automatic logic [3:0] cck_steps(input logic [1:0] rev);
        case (rev)
            2'd1:    return 4'(CCK_REV_B);
            2'd2:    return 4'(CCK_REV_C);
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/tgc_target.sv
module tgc_target
    import tgc_pkg::*;
(
    input  op_t                      op,
    output logic [TGT_W-1:0]         tgt_hdb,
    output logic signed [BASE_W-1:0] base_idx
);
    logic signed [BASE_W-1:0] reg_e, sat_e, req_e, lim;

    always_comb begin
        reg_e = $signed({3'b000, op.reg_lim}) - (op.mimo ? BASE_W'(MIMO_CUT) : '0);
        sat_e = $signed({3'b000, op.sat_lim}) - $signed({6'b0, backoff_steps(op.rate)});
        req_e = BASE_W'(op.target);
        lim   = req_e;
        if (reg_e < lim) lim = reg_e;
        if (sat_e < lim) lim = sat_e;
        if (lim < 0)                    lim = '0;
        else if (lim > BASE_W'(TGT_MAX)) lim = BASE_W'(TGT_MAX);
        tgt_hdb  = lim[TGT_W-1:0];
        base_idx = BASE_W'(op.f_idx) + BASE_W'(op.f_pwr) - $signed({5'b0, lim[TGT_W-1:0]});
    end
endmodule

// File: rtl/tgc_serdiv.sv
module tgc_serdiv #(
    parameter int DW  = 10,
    parameter int DVW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [DW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic [DW-1:0]  quo,
    output logic           busy
);
    localparam int RW = DVW + 1;
    localparam int CW = $clog2(DW + 1);

    logic [RW-1:0]  rem_q, shifted;
    logic [DVW-1:0] dvs_q;
    logic [CW-1:0]  cnt_q;
    logic           fits;

    always_comb begin
        shifted = {rem_q[RW-2:0], quo[DW-1]};
        fits    = shifted >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo   <= '0;
            dvs_q <= DVW'(1);
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo   <= dividend;
            dvs_q <= divisor;
            cnt_q <= CW'(DW);
        end else if (cnt_q != '0) begin
            rem_q <= fits ? shifted - {1'b0, dvs_q} : shifted;
            quo   <= {quo[DW-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = cnt_q != '0;

    // remainder left after a finished division is below the divisor (R3, R4)
    assert_rem_lt_div_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> (rem_q < {1'b0, dvs_q}));
endmodule

// File: rtl/tx_gain_comp.sv
module tx_gain_comp
    import tgc_pkg::*;
#(
    parameter int AW     = 4,
    parameter int NCHAIN = 2,
    parameter int NGRP   = 5,
    localparam int CSW   = $clog2(NCHAIN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [DATA_W-1:0]        target_hdb,
    input  logic [DATA_W-1:0]        reg_hdb,
    input  logic [DATA_W-1:0]        sat_hdb,
    input  logic [2:0]               rate_code,
    input  logic                     mimo,
    input  logic                     band_hi,
    input  logic [DATA_W-1:0]        chan,
    input  logic [DATA_W-1:0]        fact_idx,
    input  logic [DATA_W-1:0]        fact_hdb,
    input  logic [DATA_W-1:0]        fact_temp,
    input  logic [DATA_W-1:0]        cur_temp,
    input  logic [DATA_W-1:0]        fact_vcode,
    input  logic [DATA_W-1:0]        cur_vcode,
    input  logic [1:0]               hw_rev,
    input  logic [CSW-1:0]           chain_sel,
    input  logic [NGRP*NCHAIN*AW-1:0] atten_tab,
    output logic                     done,
    output logic [DATA_W-1:0]        gain_idx
);
    state_e  st;
    op_t     op;
    logic [AW-1:0]            atn_q;
    logic [TGT_W-1:0]         tgt_hdb;
    logic signed [BASE_W-1:0] base_idx;
    logic signed [BASE_W-1:0] tstep_q;
    logic signed [3:0]        vstep_q;

    logic                     div_load, div_busy;
    logic [DIV_W-1:0]         div_num, div_quo;
    logic [DVS_W-1:0]         div_dvs;
    logic signed [DATA_W:0]   dtemp;
    logic [DATA_W:0]          tmag;
    logic                     volt_low;
    logic [DATA_W-1:0]        vgap;
    logic [2:0]               grp;
    logic signed [ACC_W-1:0]  acc, clamped, floor_v;

    tgc_target u_target (.op(op), .tgt_hdb(tgt_hdb), .base_idx(base_idx));

    tgc_serdiv #(.DW(DIV_W), .DVW(DVS_W)) u_div (
        .clk(clk), .rst(rst), .load(div_load), .dividend(div_num),
        .divisor(div_dvs), .quo(div_quo), .busy(div_busy));

    always_comb begin
        grp      = atten_group(band_hi, chan);
        dtemp    = (DATA_W+1)'(op.c_temp) - (DATA_W+1)'(op.f_temp);
        tmag     = dtemp[DATA_W] ? (DATA_W+1)'(-dtemp) : (DATA_W+1)'(dtemp);
        volt_low = op.c_volt < op.f_volt;
        vgap     = volt_low ? op.f_volt - op.c_volt : op.c_volt - op.f_volt;
        div_load = (st == ST_PREP) || (st == ST_TDIV && !div_busy);
        if (st == ST_PREP) begin
            div_num = {tmag, 1'b0};
            div_dvs = temp_divisor(op.band_hi, op.chan);
        end else begin
            div_num = volt_low ? {2'b00, vgap} : {1'b0, vgap, 1'b0};
            div_dvs = DVS_W'(VOLT_DVS);
        end
        floor_v = op.band_hi ? ACC_W'(IDX_BOT_HI) : ACC_W'(IDX_BOT_LO);
        acc = ACC_W'(base_idx) - ACC_W'(tstep_q) + ACC_W'(vstep_q);
        if (op.mimo)              acc = acc + $signed({{(ACC_W-AW){1'b0}}, atn_q});
        if (op.rate == RC_CCK)    acc = acc + $signed({8'b0, cck_steps(op.rev)});
        if (acc > ACC_W'(IDX_TOP)) clamped = ACC_W'(IDX_TOP);
        else if (acc < floor_v)    clamped = floor_v;
        else                       clamped = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            op       <= '0;
            atn_q    <= '0;
            tstep_q  <= '0;
            vstep_q  <= '0;
            done     <= 1'b0;
            gain_idx <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    op <= '{target: target_hdb, reg_lim: reg_hdb, sat_lim: sat_hdb,
                            rate: rate_code, mimo: mimo, band_hi: band_hi, chan: chan,
                            f_idx: fact_idx, f_pwr: fact_hdb, f_temp: fact_temp,
                            c_temp: cur_temp, f_volt: fact_vcode, c_volt: cur_vcode,
                            rev: hw_rev};
                    atn_q <= atten_tab[(int'(grp)*NCHAIN + int'(chain_sel))*AW +: AW];
                    st    <= ST_PREP;
                end
                ST_PREP: st <= ST_TDIV;
                ST_TDIV: if (!div_busy) begin
                    tstep_q <= dtemp[DATA_W] ? -BASE_W'(div_quo) : BASE_W'(div_quo);
                    st      <= ST_VDIV;
                end
                ST_VDIV: if (!div_busy) begin
                    if (div_quo > DIV_W'(VOLT_CAP)) vstep_q <= '0;
                    else if (volt_low)              vstep_q <= 4'(div_quo[1:0]);
                    else                            vstep_q <= -4'(div_quo[1:0]);
                    st <= ST_FIN;
                end
                ST_FIN: begin
                    gain_idx <= clamped[DATA_W-1:0];
                    done     <= 1'b1;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(gain_idx));
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(gain_idx) <= 8'sd98 && $signed(gain_idx) >= -8'sd9));
    assert_low_band_floor_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !op.band_hi) |-> $signed(gain_idx) >= 8'sd0);
    assert_tgt_range_R1: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |-> tgt_hdb <= TGT_W'(TGT_MAX));
    assert_temp_dir_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VDIV && $signed(op.c_temp) > $signed(op.f_temp)) |-> tstep_q >= 0);
endmodule

// File: tb/tx_gain_comp_tb.sv
module tx_gain_comp_tb;
    localparam int LAT = 24;

    logic clk = 0, rst = 1, start = 0;
    logic [7:0] target_hdb, reg_hdb, sat_hdb, chan, fact_idx, fact_hdb;
    logic [7:0] fact_temp, cur_temp, fact_vcode, cur_vcode;
    logic [2:0] rate_code;
    logic mimo, band_hi, chain_sel;
    logic [1:0] hw_rev;
    logic [39:0] atten_tab;
    logic done;
    logic [7:0] gain_idx;

    int vectors = 0, miscompares = 0, cycles = 0;
    int prev_idx = 0;

    tx_gain_comp u_dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic int ref_idx();
        int bo, t, rl, sl, idx, dt, m, q, v, g, lo;
        case (rate_code)
            3'd2: bo = 15; 3'd3: bo = 17; 3'd4: bo = 20; default: bo = 10;
        endcase
        rl = int'(reg_hdb) - (mimo ? 6 : 0);
        sl = int'(sat_hdb) - bo;
        t = int'($signed(target_hdb));
        if (rl < t) t = rl;
        if (sl < t) t = sl;
        if (t < 0) t = 0;
        if (t > 32) t = 32;
        idx = int'($signed(fact_idx)) + int'($signed(fact_hdb)) - t;
        dt = int'($signed(cur_temp)) - int'($signed(fact_temp));
        m = dt < 0 ? -dt : dt;
        if (!band_hi) q = (2*m)/7;
        else if (chan < 44) q = (2*m)/9;
        else q = (2*m)/8;
        idx = dt < 0 ? idx + q : idx - q;
        if (cur_vcode < fact_vcode) begin
            v = (int'(fact_vcode) - int'(cur_vcode))/7;
            if (v > 2) v = 0;
            idx += v;
        end else if (cur_vcode > fact_vcode) begin
            v = (2*(int'(cur_vcode) - int'(fact_vcode)))/7;
            if (v > 2) v = 0;
            idx -= v;
        end
        if (mimo) begin
            if (!band_hi) g = 4;
            else if (chan <= 43) g = 0;
            else if (chan <= 70) g = 1;
            else if (chan <= 124) g = 2;
            else g = 3;
            idx += int'(atten_tab[(g*2+int'(chain_sel))*4 +: 4]);
        end
        if (rate_code == 3'd0) idx += (hw_rev == 2'd1) ? 9 : (hw_rev == 2'd2) ? 5 : 0;
        lo = band_hi ? -9 : 0;
        if (idx > 98) idx = 98;
        if (idx < lo) idx = lo;
        return idx;
    endfunction

    task automatic neutral();
        target_hdb = 8'd20; reg_hdb = 8'd34; sat_hdb = 8'd50; rate_code = 3'd1;
        mimo = 0; band_hi = 0; chan = 8'd6; fact_idx = 8'd40; fact_hdb = 8'd20;
        fact_temp = 8'd30; cur_temp = 8'd30; fact_vcode = 8'd100; cur_vcode = 8'd100;
        hw_rev = 2'd0; chain_sel = 0; atten_tab = 40'h0;
    endtask

    task automatic run_vec(input string tag, input bit poke);
        int exp_v, got;
        bit bad_seq;
        exp_v = ref_idx();
        bad_seq = 0;
        @(negedge clk); start = 1;
        @(posedge clk); #1 start = 0;
        for (int k = 1; k <= LAT; k++) begin
            if (poke && k == 5) begin
                start = 1; target_hdb = 8'd0; fact_idx = 8'd7; cur_temp = 8'd100;
            end
            @(posedge clk); #1;
            if (poke && k == 5) start = 0;
            if (k < LAT) begin
                if (done || int'($signed(gain_idx)) != prev_idx) bad_seq = 1;
            end
        end
        vectors++;
        got = int'($signed(gain_idx));
        if (!done || got != exp_v) begin
            miscompares++;
            $display("FAIL %s: actual idx=%0d done=%0b, expected idx=%0d done=1", tag, got, done, exp_v);
        end
        vectors++;
        if (bad_seq) begin
            miscompares++;
            $display("FAIL R9 (%s): actual early done or output change before edge %0d, expected hold", tag, LAT);
        end
        prev_idx = got;
        @(posedge clk); #1;
        vectors++;
        if (done) begin
            miscompares++;
            $display("FAIL R9 (%s): actual done=1 one cycle later, expected 0", tag);
        end
    endtask

    initial begin
        neutral();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        vectors++;
        if (done !== 1'b0 || gain_idx !== 8'd0) begin
            miscompares++;
            $display("FAIL R10: actual done=%0b idx=%0d, expected 0 0", done, gain_idx);
        end

        neutral(); run_vec("R2", 0);
        neutral(); target_hdb = 8'd40; reg_hdb = 8'd30; run_vec("R1", 0);
        neutral(); target_hdb = 8'd40; rate_code = 3'd4; sat_hdb = 8'd45; run_vec("R1", 0);
        neutral(); target_hdb = 8'd60; reg_hdb = 8'd80; sat_hdb = 8'd90; run_vec("R1", 0);
        neutral(); target_hdb = 8'hF6; run_vec("R1", 0);
        neutral(); mimo = 1; target_hdb = 8'd34; run_vec("R1", 0);
        neutral(); cur_temp = 8'd37; run_vec("R3", 0);
        neutral(); cur_temp = 8'd36; run_vec("R3", 0);
        neutral(); band_hi = 1; chan = 8'd43; cur_temp = 8'd21; run_vec("R3", 0);
        neutral(); band_hi = 1; chan = 8'd44; cur_temp = 8'd38; run_vec("R3", 0);
        neutral(); cur_temp = 8'd25; run_vec("R3", 0);
        neutral(); cur_vcode = 8'd86; run_vec("R4", 0);
        neutral(); cur_vcode = 8'd107; run_vec("R4", 0);
        neutral(); cur_vcode = 8'd79; run_vec("R5", 0);
        neutral(); cur_vcode = 8'd111; run_vec("R5", 0);
        neutral(); mimo = 1; band_hi = 1; chan = 8'd124; chain_sel = 1;
        atten_tab = 40'h9876543210; run_vec("R6", 0);
        neutral(); mimo = 1; band_hi = 1; chan = 8'd125; chain_sel = 0;
        atten_tab = 40'h9876543210; run_vec("R6", 0);
        neutral(); mimo = 1; chain_sel = 1; atten_tab = 40'hF000000000; run_vec("R6", 0);
        neutral(); rate_code = 3'd0; hw_rev = 2'd1; run_vec("R7", 0);
        neutral(); rate_code = 3'd0; hw_rev = 2'd2; run_vec("R7", 0);
        neutral(); rate_code = 3'd0; hw_rev = 2'd3; run_vec("R7", 0);
        neutral(); fact_idx = 8'd120; run_vec("R8", 0);
        neutral(); band_hi = 1; chan = 8'd100; fact_idx = 8'hE0; run_vec("R8", 0);
        neutral(); fact_idx = 8'hE0; run_vec("R8", 0);
        neutral(); run_vec("R9", 1);

        for (int n = 0; n < 300; n++) begin
            target_hdb = 8'($urandom_range(80)) - 8'd10;
            reg_hdb = 8'($urandom_range(50)); sat_hdb = 8'($urandom_range(60));
            rate_code = 3'($urandom_range(7)); mimo = 1'($urandom_range(1));
            band_hi = 1'($urandom_range(1)); chan = 8'($urandom_range(200));
            fact_idx = 8'($urandom_range(110)) - 8'd5;
            fact_hdb = 8'($urandom_range(40));
            fact_temp = 8'($urandom_range(60)) - 8'd10;
            cur_temp = 8'($urandom_range(120)) - 8'd20;
            fact_vcode = 8'($urandom_range(255)); cur_vcode = 8'($urandom_range(255));
            if (n % 2 == 0) cur_vcode = fact_vcode + 8'($urandom_range(30)) - 8'd15;
            hw_rev = 2'($urandom_range(3)); chain_sel = 1'($urandom_range(1));
            atten_tab = {8'($urandom), 32'($urandom)};
            run_vec("R1 random mix", 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule